// File: doc/BRIEF.md
# Peak Current Reference Generator

This block produces the 8-bit reference that a current-sense comparator uses to end each switching cycle of a flyback converter. One code of the reference stands for 400 mV / 256 at the comparator. There are two sources. While soft-start runs, the reference is a ramp. It begins at a configurable start level and climbs by a fixed number of codes at a fixed interval. The default interval is 13035 clocks at 250 MHz, about 52 µs per one-code step.

Soft-start ends in one of two ways:
- the ramp reaches the configured ceiling;
- the feedback input reports that the error voltage has fallen below its threshold.

Once soft-start has ended, the reference tracks a commanded value from the frequency-law logic. An offset is taken away from that value. The offset grows as the sensed output voltage drops, which keeps peak current down when the output sits low. A soft-start request restarts the ramp, for example on initial power-up or after an auto-restart break.

The offset is computed from the 8-bit output-voltage ADC code `zcd`, a slope `K` and a zero point `Z`:
- offset = floor(K·(Z − zcd) / 65536) when zcd < Z;
- offset = 0 otherwise.

The subtraction from the command saturates at zero.

Top module: `pk_ref_gen`

## Requirements
- R1: The reset `rst_ni` is active low and asynchronous. While it is low and at the first sample after it is applied, `ref_o` reads 0 and no soft-start is running. After reset, the reference follows the commanded path until a soft-start request arrives.
- R2: A soft-start request `ss_req_i` sampled high at a clock edge loads min(`cfg_start_i`, `cfg_max_i`) into the ramp. `ref_o` shows that value after the following edge.
- R3: While soft-start runs with `fb_high_i` = 1, the ramp rises by STEP_CODES codes every STEP_CYCLES clocks. The first rise comes STEP_CYCLES edges after the request edge. The offset and `cmd_ref_i` have no effect on `ref_o` during the ramp.
- R4: The ramp never exceeds `cfg_max_i`. On reaching it, `ref_o` shows `cfg_max_i` for one cycle. `ref_o` then follows the commanded path.
- R5: `fb_high_i` = 0 while soft-start runs ends soft-start at the next edge. The ramp does not resume while `fb_high_i` later returns high.
- R6: The offset is floor(`cfg_k_i`·(`cfg_zero_i` − `zcd_code_i`)/65536) when `zcd_code_i` < `cfg_zero_i`, and 0 otherwise. Example: K = 20000 and Z = 79 at code 0 give 24.
- R7: Outside soft-start, `ref_o` = `cmd_ref_i` − offset, saturating at 0 with no wrap. A change of `cmd_ref_i` appears after one edge. A change of `zcd_code_i`, `cfg_k_i` or `cfg_zero_i` appears after two edges.
- R8: A request with `cfg_start_i` ≥ `cfg_max_i` skips soft-start. `ref_o` follows the commanded path.
- R9: A request during a running ramp restarts it from the current start level, overriding the ramp value and the step timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ss_req_i | input | 1 | Soft-start request, sampled each edge |
| fb_high_i | input | 1 | High while feedback voltage is above the soft-start exit threshold |
| cmd_ref_i | input | 8 | Commanded peak reference from the frequency law |
| zcd_code_i | input | 8 | Output-voltage ADC code, 0..255 |
| cfg_start_i | input | 8 | Soft-start start level |
| cfg_max_i | input | 8 | Soft-start ceiling |
| cfg_k_i | input | 16 | Offset slope K |
| cfg_zero_i | input | 8 | Offset zero point |
| ref_o | output | 8 | Peak current reference code |

## Verification
The assertions on ramp bounds and monotonic steps take two things for granted about the inputs:
- the configuration inputs are held stable while a soft-start runs;
- every input is synchronous to `clk_i`.

The stimulus changes the start level, ceiling, slope and zero point only while no ramp is running, or together with a fresh request. It keeps `fb_high_i` high during ramps, except in the one case that checks early exit. The offset vectors reach the extremes of code 0 and the zero point, the largest slope, and commands that sit just at or just above the offset, so the saturating subtraction is hit from both sides.

// File: rtl/pk_ref_pkg.sv
package pk_ref_pkg;
  typedef enum logic {
    SRC_LAW  = 1'b0,
    SRC_RAMP = 1'b1
  } ref_src_e;
endpackage

// File: rtl/pk_ss_ramp.sv
module pk_ss_ramp #(
  parameter int REF_W       = 8,
  parameter int STEP_CYCLES = 13035,
  parameter int STEP_CODES  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             fb_high_i,
  input  logic [REF_W-1:0] start_i,
  input  logic [REF_W-1:0] max_i,
  output logic [REF_W-1:0] ramp_o,
  output logic             active_o
);
  localparam logic [REF_W:0] STEP_EXT = (REF_W+1)'(STEP_CODES);

  logic [REF_W-1:0] ramp_q;
  logic             active_q;
  logic             tick;
  logic [REF_W-1:0] start_clip;
  logic [REF_W:0]   sum;
  logic [REF_W-1:0] next_up;

  generate
    if (STEP_CYCLES > 1) begin : g_timer
      localparam int CNT_W = $clog2(STEP_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  cnt_q <= '0;
        else if (req_i || !active_q)  cnt_q <= '0;
        else if (cnt_q == LAST)       cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
      end
      assign tick = active_q && (cnt_q == LAST);
    end else begin : g_every
      assign tick = active_q;
    end
  endgenerate

  assign start_clip = (start_i < max_i) ? start_i : max_i;
  assign sum        = {1'b0, ramp_q} + STEP_EXT;
  assign next_up    = (sum >= {1'b0, max_i}) ? max_i : sum[REF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q   <= '0;
      active_q <= 1'b0;
    end else if (req_i) begin
      ramp_q   <= start_clip;
      active_q <= (start_i < max_i);
    end else if (active_q) begin
      if (!fb_high_i || ramp_q >= max_i) active_q <= 1'b0;
      else if (tick)                     ramp_q   <= next_up;
    end
  end

  assign ramp_o   = ramp_q;
  assign active_o = active_q;

  // R2
  p_req_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ramp_q == (($past(start_i) < $past(max_i)) ? $past(start_i) : $past(max_i)));
  // R3
  p_ramp_mono_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !req_i) |=> ramp_q >= $past(ramp_q));
  // R3
  p_ramp_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !req_i) |=> ({1'b0, ramp_q} - {1'b0, $past(ramp_q)}) <= STEP_EXT);
  // R4
  p_ramp_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> ramp_q <= max_i);
  // R5
  p_fb_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !fb_high_i) |=> !active_q);
  // R8
  p_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && start_i >= max_i) |=> !active_q);
endmodule

// File: rtl/pk_vo_offset.sv
module pk_vo_offset #(
  parameter int ADC_W = 8,
  parameter int K_W   = 16,
  parameter int REF_W = 8,
  parameter int SHIFT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADC_W-1:0] zcd_i,
  input  logic [ADC_W-1:0] zero_i,
  input  logic [K_W-1:0]   k_i,
  output logic [REF_W-1:0] off_o
);
  localparam int PROD_W = ADC_W + K_W;
  localparam int Q_W    = PROD_W - SHIFT;

  logic [ADC_W-1:0]  diff;
  logic [PROD_W-1:0] prod;
  logic [Q_W-1:0]    quo;
  logic [REF_W-1:0]  off_d;
  logic [REF_W-1:0]  off_q;
  logic              unused_frac;

  assign diff        = (zcd_i < zero_i) ? (zero_i - zcd_i) : '0;
  assign prod        = PROD_W'(diff) * PROD_W'(k_i);
  assign quo         = prod[PROD_W-1:SHIFT];
  assign unused_frac = ^prod[SHIFT-1:0];

  generate
    if (Q_W > REF_W) begin : g_clamp
      assign off_d = (|quo[Q_W-1:REF_W]) ? '1 : quo[REF_W-1:0];
    end else begin : g_fit
      assign off_d = REF_W'(quo);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= off_d;
  end

  assign off_o = off_q;

  // R6
  p_off_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zcd_i >= zero_i) |=> off_q == '0);
  // R6
  p_off_nok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_i == '0) |=> off_q == '0);
endmodule

// File: rtl/pk_ref_sel.sv
module pk_ref_sel
  import pk_ref_pkg::*;
#(
  parameter int REF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ref_src_e         src_i,
  input  logic [REF_W-1:0] ramp_i,
  input  logic [REF_W-1:0] cmd_i,
  input  logic [REF_W-1:0] off_i,
  output logic [REF_W-1:0] ref_o
);
  logic [REF_W-1:0] law;
  logic [REF_W-1:0] ref_q;

  assign law = (cmd_i > off_i) ? (cmd_i - off_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ref_q <= '0;
    else if (src_i == SRC_RAMP)  ref_q <= ramp_i;
    else                         ref_q <= law;
  end

  assign ref_o = ref_q;

  // R7
  p_law_le_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_LAW) |=> ref_q <= $past(cmd_i));
  // R7
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_LAW && cmd_i <= off_i) |=> ref_q == '0);
  // R3
  p_ramp_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_RAMP) |=> ref_q == $past(ramp_i));
endmodule

// File: rtl/pk_ref_gen.sv
module pk_ref_gen
  import pk_ref_pkg::*;
#(
  parameter int REF_W       = 8,
  parameter int ADC_W       = 8,
  parameter int K_W         = 16,
  parameter int DIV_SHIFT   = 16,
  parameter int STEP_CYCLES = 13035,
  parameter int STEP_CODES  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_req_i,
  input  logic             fb_high_i,
  input  logic [REF_W-1:0] cmd_ref_i,
  input  logic [ADC_W-1:0] zcd_code_i,
  input  logic [REF_W-1:0] cfg_start_i,
  input  logic [REF_W-1:0] cfg_max_i,
  input  logic [K_W-1:0]   cfg_k_i,
  input  logic [ADC_W-1:0] cfg_zero_i,
  output logic [REF_W-1:0] ref_o
);
  logic [REF_W-1:0] ramp;
  logic             ss_active;
  logic [REF_W-1:0] off;
  ref_src_e         src;

  pk_ss_ramp #(
    .REF_W      (REF_W),
    .STEP_CYCLES(STEP_CYCLES),
    .STEP_CODES (STEP_CODES)
  ) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (ss_req_i),
    .fb_high_i(fb_high_i),
    .start_i  (cfg_start_i),
    .max_i    (cfg_max_i),
    .ramp_o   (ramp),
    .active_o (ss_active)
  );

  pk_vo_offset #(
    .ADC_W(ADC_W),
    .K_W  (K_W),
    .REF_W(REF_W),
    .SHIFT(DIV_SHIFT)
  ) u_off (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .zcd_i (zcd_code_i),
    .zero_i(cfg_zero_i),
    .k_i   (cfg_k_i),
    .off_o (off)
  );

  assign src = ss_active ? SRC_RAMP : SRC_LAW;

  pk_ref_sel #(
    .REF_W(REF_W)
  ) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src),
    .ramp_i(ramp),
    .cmd_i (cmd_ref_i),
    .off_i (off),
    .ref_o (ref_o)
  );
endmodule

// File: tb/pk_ref_gen_bench.sv
`timescale 1ns/1ps
module pk_ref_gen_bench;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ss_req = 1'b0;
  logic        fb_high = 1'b1;
  logic [7:0]  cmd = 8'd0;
  logic [7:0]  zcd = 8'd255;
  logic [7:0]  c_start = 8'd10;
  logic [7:0]  c_max = 8'd20;
  logic [15:0] c_k = 16'd20000;
  logic [7:0]  c_zero = 8'd79;
  logic [7:0]  ref_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pk_ref_gen #(.STEP_CYCLES(STEP), .STEP_CODES(1)) u_pk_ref_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ss_req_i(ss_req), .fb_high_i(fb_high),
    .cmd_ref_i(cmd), .zcd_code_i(zcd), .cfg_start_i(c_start), .cfg_max_i(c_max),
    .cfg_k_i(c_k), .cfg_zero_i(c_zero), .ref_o(ref_o)
  );

  // cmd, zcd, k, zero, expected ref
  localparam logic [47:0] VEC [11] = '{
    {8'd200, 8'd0,   16'd20000, 8'd79,  8'd176},
    {8'd200, 8'd79,  16'd20000, 8'd79,  8'd200},
    {8'd200, 8'd255, 16'd20000, 8'd79,  8'd200},
    {8'd10,  8'd0,   16'd20000, 8'd79,  8'd0},
    {8'd100, 8'd40,  16'd65535, 8'd255, 8'd0},
    {8'd255, 8'd200, 16'd65535, 8'd255, 8'd201},
    {8'd128, 8'd50,  16'd32768, 8'd100, 8'd103},
    {8'd128, 8'd100, 16'd32768, 8'd100, 8'd128},
    {8'd50,  8'd0,   16'd0,     8'd255, 8'd50},
    {8'd24,  8'd0,   16'd20000, 8'd79,  8'd0},
    {8'd25,  8'd0,   16'd20000, 8'd79,  8'd1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ref_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  // wait k rising edges, then settle at the falling edge
  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  // request sampled at the next edge (E0); returns at the negedge after E0
  task automatic pulse_req();
    @(negedge clk);
    ss_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ss_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: ref_o=%0d expected completion", ref_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 reset", ref_o, 8'd0);
    rst_ni = 1'b1;

    // R6 R7: offset and saturating subtraction vectors
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      {cmd, zcd, c_k, c_zero} = VEC[i][47:8];
      edges(3);
      chk($sformatf("R6/R7 vec %0d", i), ref_o, VEC[i][7:0]);
    end

    // R7 cmd latency: one edge
    @(negedge clk);
    c_k = 16'd20000; c_zero = 8'd79; zcd = 8'd0; cmd = 8'd150;
    edges(3);
    chk("R7 law 150-24", ref_o, 8'd126);
    cmd = 8'd100;
    edges(1);
    chk("R7 cmd one-edge", ref_o, 8'd76);
    cmd = 8'd150;
    edges(2);

    // R2 R3 R4: ramp 10 -> 20, offset ignored
    c_start = 8'd10; c_max = 8'd20; fb_high = 1'b1;
    pulse_req();
    edges(1);
    chk("R2 start load", ref_o, 8'd10);
    cmd = 8'd3;  // R3: command ignored during ramp
    edges(12);
    chk("R3 three steps", ref_o, 8'd13);
    cmd = 8'd150;
    edges(24);
    chk("R3 nine steps", ref_o, 8'd19);
    edges(4);
    chk("R4 at max", ref_o, 8'd20);
    edges(4);
    chk("R4 follows law", ref_o, 8'd126);

    // R5: feedback drop ends soft-start
    pulse_req();
    edges(1);
    chk("R5 ramp started", ref_o, 8'd10);
    fb_high = 1'b0;
    edges(2);
    chk("R5 early exit", ref_o, 8'd126);
    fb_high = 1'b1;
    edges(10);
    chk("R5 no resume", ref_o, 8'd126);

    // R9: restart during ramp with new start level
    pulse_req();
    edges(9);
    chk("R9 ramp mid", ref_o, 8'd12);
    c_start = 8'd5;
    pulse_req();
    edges(1);
    chk("R9 restart load", ref_o, 8'd5);
    edges(8);
    chk("R9 restart timer", ref_o, 8'd7);
    edges(70);
    chk("R9 ends on law", ref_o, 8'd126);

    // R8: start at or above max skips soft-start
    c_start = 8'd20;
    pulse_req();
    edges(1);
    chk("R8 start==max", ref_o, 8'd126);
    c_start = 8'd30;
    pulse_req();
    edges(5);
    chk("R8 start>max", ref_o, 8'd126);

    // R1: asynchronous reset mid-ramp
    c_start = 8'd10;
    pulse_req();
    edges(6);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async reset", ref_o, 8'd0);
    edges(1);
    rst_ni = 1'b1;
    edges(2);
    chk("R1 no ramp after reset", ref_o, 8'd126);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule